// File: doc/BRIEF.md
# Scanline-Counting IRQ Generator

This block raises a CPU interrupt once a programmed number of visible scanlines has passed. An address decoder elsewhere turns CPU writes into four one-cycle strobes, all of which share one data byte. The strobes load the counter, load the reload latch, disarm the generator and arm it. The video side supplies a one-cycle pulse at the start of each scanline, the number of that line, and a flag that is high while rendering is on.

Each qualifying line tests the counter first and decrements it afterwards. When the counter is zero at the test, the block sets an internal pending flag and asserts the interrupt line, and it reloads the counter from the latch. The first visible line takes one extra decrement if the counter is nonzero. The interrupt is a level. Only the disarm strobe drops it.

Top module: `scanline_irq_gen`

## Requirements
- R1: After reset the interrupt output is low and the counter, the reload latch, the armed flag and the pending flag are all zero. Without any write, arming alone makes the first qualifying line fire, and after a fire the counter reloads to zero.
- R2: A pulse on `wr_cnt` loads `wr_data` into the counter and clears the pending flag.
- R3: A pulse on `wr_latch` loads `wr_data` into the reload latch and clears the pending flag.
- R4: A pulse on `wr_disarm` clears the armed flag and the pending flag, and `irq` is low from the next cycle on.
- R5: A pulse on `wr_arm` sets the armed flag and clears the pending flag. It leaves an `irq` that is already high unchanged.
- R6: The counter advances only on a `line_pulse` whose `line_num` lies in 0..239 while `render_en` is high, the block is armed and no request is pending. All other line pulses leave it unchanged.
- R7: On a qualifying line whose counter value (after the R8 adjustment) is zero, the block sets the pending flag and `irq`, and the counter takes the latch value. Otherwise the counter decrements by one. With a counter N loaded and counting starting at line s > 0, the fire happens on line s+N.
- R8: On line 0 a nonzero counter is decremented once before the R7 step. Counting from line 0 with counter N therefore fires on line 0 when N <= 1, and on line N-1 otherwise.
- R9: When any write strobe coincides with `line_pulse`, that line's step is skipped and only the write takes effect.
- R10: `irq` is a level. Once high, it stays high through later line pulses and writes until `wr_disarm` is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cnt | input | 1 | Strobe: load the counter from wr_data |
| wr_latch | input | 1 | Strobe: load the reload latch from wr_data |
| wr_disarm | input | 1 | Strobe: disarm and drop the interrupt |
| wr_arm | input | 1 | Strobe: arm the generator |
| wr_data | input | 8 | Write data shared by all strobes |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Number of the current scanline |
| render_en | input | 1 | High while rendering is enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The counter cannot be seen at the ports. Every count is therefore measured as the line on which `irq` first rises, and the bench sweeps the loaded value and the starting line, including line 0 and starts that run past line 239. The hardest state to reach is the reload after a fire. While a request is pending the counter is frozen and `irq` hides any further fire. The bench reaches this state by firing, holding lines with the request pending, releasing the pending flag with an arm write, then disarming and rearming so that the next rise of `irq` shows the reloaded value. The write-over-line priority is exercised by landing a latch write on the same cycle as a line pulse, which moves the fire by exactly one line.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

  typedef struct packed {
    logic load_cnt;
    logic load_latch;
    logic disarm;
    logic arm;
  } irq_wr_t;

  function automatic logic any_write(input irq_wr_t w);
    return w.load_cnt | w.load_latch | w.disarm | w.arm;
  endfunction

endpackage

// File: rtl/scanline_irq_qual.sv
module scanline_irq_qual #(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              line_pulse,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_en,
  input  logic              armed,
  input  logic              pending,
  input  logic              write_busy,
  output logic              step_en,
  output logic              first_line
);
  localparam logic [LINE_W-1:0] LAST_V = LINE_W'(LAST_LINE);

  function automatic logic visible(input logic [LINE_W-1:0] n);
    return n <= LAST_V;
  endfunction

  always_comb begin
    first_line = (line_num == '0);
    step_en    = line_pulse & visible(line_num) & render_en & armed
               & ~pending & ~write_busy;
  end
endmodule

// File: rtl/scanline_irq_step.sv
module scanline_irq_step #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             first_line,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             zero_hit
);
  // Returns {test result, decremented value}
  function automatic logic [CNT_W:0] line_step(input logic [CNT_W-1:0] c,
                                               input logic             first);
    logic [CNT_W-1:0] adj;
    adj = (first && c != '0) ? c - CNT_W'(1) : c;
    return {adj == '0, adj - CNT_W'(1)};
  endfunction

  always_comb begin
    {zero_hit, cnt_dec} = line_step(cnt, first_line);
  end
endmodule

// File: rtl/scanline_irq_ctrl.sv
module scanline_irq_ctrl
  import scanline_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  irq_wr_t wr,
  input  logic    fire_evt,
  output logic    armed_q,
  output logic    pending_q,
  output logic    irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr.disarm)   armed_q <= 1'b0;
      else if (wr.arm) armed_q <= 1'b1;

      if (any_write(wr))  pending_q <= 1'b0;
      else if (fire_evt)  pending_q <= 1'b1;

      if (wr.disarm)      irq_q <= 1'b0;
      else if (fire_evt)  irq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cnt,
  input  logic              wr_latch,
  input  logic              wr_disarm,
  input  logic              wr_arm,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_pulse,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_en,
  output logic              irq
);
  irq_wr_t          wr;
  logic             write_busy;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_dec;
  logic             zero_hit;
  logic             step_en;
  logic             first_line;
  logic             fire_evt;
  logic             armed_q;
  logic             pending_q;
  logic             irq_q;

  always_comb begin
    wr.load_cnt   = wr_cnt;
    wr.load_latch = wr_latch;
    wr.disarm     = wr_disarm;
    wr.arm        = wr_arm;
    write_busy    = any_write(wr);
    fire_evt      = step_en & zero_hit;
  end

  scanline_irq_qual #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_qual (
    .line_pulse (line_pulse),
    .line_num   (line_num),
    .render_en  (render_en),
    .armed      (armed_q),
    .pending    (pending_q),
    .write_busy (write_busy),
    .step_en    (step_en),
    .first_line (first_line)
  );

  scanline_irq_step #(.CNT_W(CNT_W)) u_step (
    .cnt        (count_q),
    .first_line (first_line),
    .cnt_dec    (cnt_dec),
    .zero_hit   (zero_hit)
  );

  scanline_irq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr),
    .fire_evt  (fire_evt),
    .armed_q   (armed_q),
    .pending_q (pending_q),
    .irq_q     (irq_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      latch_q <= '0;
    end else begin
      if (wr.load_cnt)   count_q <= wr_data;
      else if (step_en)  count_q <= zero_hit ? latch_q : cnt_dec;
      if (wr.load_latch) latch_q <= wr_data;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_cnt,
  input logic              wr_latch,
  input logic              wr_disarm,
  input logic              wr_arm,
  input logic [CNT_W-1:0]  wr_data,
  input logic              line_pulse,
  input logic [LINE_W-1:0] line_num,
  input logic              irq,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  latch_q,
  input logic              pending_q,
  input logic              armed_q,
  input logic              fire_evt
);
  logic any_wr;
  assign any_wr = wr_cnt | wr_latch | wr_disarm | wr_arm;

  AST_RESET_VALUES: assert property (@(posedge clk)
    !rst_n |=> (count_q == '0 && latch_q == '0 && !pending_q && !armed_q && !irq)); // R1
  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count_q == $past(wr_data) && !pending_q)); // R2
  AST_LOAD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> (latch_q == $past(wr_data) && !pending_q)); // R3
  AST_DISARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disarm |=> (!irq && !armed_q && !pending_q)); // R4
  AST_ARM_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_arm && !wr_disarm && irq) |=> (irq && armed_q && !pending_q)); // R5
  AST_OFF_RANGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pulse && line_num > LINE_W'(LAST_LINE) && !any_wr) |=> $stable(count_q)); // R6
  AST_FIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> (count_q == $past(latch_q) && irq && pending_q)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pulse && !wr_cnt && (wr_latch || wr_arm || wr_disarm)) |=> $stable(count_q)); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_disarm) |=> irq); // R10
endmodule

bind scanline_irq_gen scanline_irq_chk #(
  .CNT_W(CNT_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_cnt     (wr_cnt),
  .wr_latch   (wr_latch),
  .wr_disarm  (wr_disarm),
  .wr_arm     (wr_arm),
  .wr_data    (wr_data),
  .line_pulse (line_pulse),
  .line_num   (line_num),
  .irq        (irq),
  .count_q    (count_q),
  .latch_q    (latch_q),
  .pending_q  (pending_q),
  .armed_q    (armed_q),
  .fire_evt   (fire_evt)
);

// File: tb/scanline_irq_gen_bench.sv
`timescale 1ns/1ps
module scanline_irq_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_cnt = 1'b0, wr_latch = 1'b0, wr_disarm = 1'b0, wr_arm = 1'b0;
  logic [7:0] wr_data = '0;
  logic       line_pulse = 1'b0;
  logic [8:0] line_num = '0;
  logic       render_en = 1'b1;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scanline_irq_gen u_scanline_irq_gen (
    .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_latch(wr_latch),
    .wr_disarm(wr_disarm), .wr_arm(wr_arm), .wr_data(wr_data),
    .line_pulse(line_pulse), .line_num(line_num), .render_en(render_en),
    .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 counter, 1 latch, 2 disarm, 3 arm
  task automatic do_write(input int kind, input int data);
    @(negedge clk);
    wr_data   = 8'(data);
    wr_cnt    = (kind == 0);
    wr_latch  = (kind == 1);
    wr_disarm = (kind == 2);
    wr_arm    = (kind == 3);
    @(negedge clk);
    {wr_cnt, wr_latch, wr_disarm, wr_arm} = '0;
  endtask

  task automatic one_line(input int ln);
    @(negedge clk);
    line_pulse = 1'b1;
    line_num   = 9'(ln);
    @(negedge clk);
    line_pulse = 1'b0;
  endtask

  // Runs lines from s up to 261, returns first line where irq is seen high
  task automatic run_to_fire(input int s, output int hit);
    hit = -1;
    for (int ln = s; ln <= 261; ln++) begin
      one_line(ln);
      if (irq) begin
        hit = ln;
        return;
      end
    end
  endtask

  task automatic arm_with(input int n);
    do_write(2, 0);
    do_write(0, n);
    do_write(3, 0);
  endtask

  function automatic int expect_line(input int n, input int s);
    int e;
    if (s == 0) return (n <= 1) ? 0 : n - 1;
    e = s + n;
    return (e > 239) ? -1 : e;
  endfunction

  initial begin : wdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R1 reset irq", int'(irq), 0);

    // R1: not armed after reset, nothing fires
    run_to_fire(5, hit);
    check(hit == -1, "R1 armed clear at reset", hit, -1);
    // R1: counter zero at reset -> first qualifying line fires
    do_write(3, 0);
    run_to_fire(5, hit);
    check(hit == 5, "R1 counter zero at reset", hit, 5);
    // R1/R7: reload came from reset latch zero
    do_write(2, 0);
    do_write(3, 0);
    run_to_fire(7, hit);
    check(hit == 7, "R1 latch zero at reset", hit, 7);

    // R2 R6 R7 R8: sweep of loaded value and start line
    for (int n = 0; n <= 40; n++) begin
      for (int k = 0; k < 3; k++) begin
        int s;
        int exp;
        s = (k == 0) ? 0 : (k == 1) ? 1 : 205;
        arm_with(n);
        run_to_fire(s, hit);
        exp = expect_line(n, s);
        check(hit == exp, (s == 0) ? "R8 line0 sweep" : "R2/R7 sweep", hit, exp);
      end
    end

    // R6: rendering off blocks counting
    arm_with(3);
    render_en = 1'b0;
    run_to_fire(10, hit);
    check(hit == -1, "R6 render off", hit, -1);
    render_en = 1'b1;
    run_to_fire(10, hit);
    check(hit == 13, "R6 render back on", hit, 13);

    // R7 R10 R5 R4: reload and level behaviour
    do_write(1, 3);
    arm_with(0);
    run_to_fire(10, hit);
    check(hit == 10, "R7 fire on zero", hit, 10);
    for (int ln = 11; ln <= 20; ln++) one_line(ln);
    check(irq == 1'b1, "R10 irq held over lines", int'(irq), 1);
    do_write(3, 0);
    check(irq == 1'b1, "R5 arm keeps irq", int'(irq), 1);
    do_write(2, 0);
    check(irq == 1'b0, "R4 disarm drops irq", int'(irq), 0);
    do_write(3, 0);
    run_to_fire(30, hit);
    check(hit == 33, "R7 reload from latch", hit, 33);
    do_write(1, 9);
    check(irq == 1'b1, "R10 irq held over write", int'(irq), 1);

    // R3: latch load observed via reload
    do_write(1, 5);
    arm_with(0);
    run_to_fire(40, hit);
    check(hit == 40, "R3 fire before reload", hit, 40);
    do_write(2, 0);
    do_write(3, 0);
    run_to_fire(60, hit);
    check(hit == 65, "R3 latch value used", hit, 65);

    // R9: write coincident with line pulse skips the step
    arm_with(2);
    @(negedge clk);
    line_pulse = 1'b1; line_num = 9'd50; wr_latch = 1'b1; wr_data = 8'd7;
    @(negedge clk);
    line_pulse = 1'b0; wr_latch = 1'b0;
    run_to_fire(51, hit);
    check(hit == 53, "R9 write wins over line", hit, 53);

    // R6: off-screen lines ignored
    arm_with(1);
    for (int ln = 240; ln <= 261; ln++) one_line(ln);
    run_to_fire(100, hit);
    check(hit == 101, "R6 off-screen lines ignored", hit, 101);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule